// File: doc/BRIEF.md
# DMA Burst Request Generator

This block sits on the peripheral side of a system DMA channel. It lends the bus to the DMA controller for short bursts of fixed length. Software starts a burst by writing to one I/O address. The value written plays no part, so the block has no data input. The block then raises its DMA request and keeps it raised while the controller moves bytes, one per acknowledge cycle. It drops the request when the burst length is reached, or sooner if the controller reports terminal count.

A byte is counted when the per-byte transfer strobe rises while the acknowledge is high. Each start clears the byte counter. A further control write during a burst has no effect, so a burst cannot be lengthened or restarted, and nothing but the length limit or terminal count can end it. When a burst ends, the block goes back to idle. It gives a one-cycle completion pulse and keeps a flag that tells whether terminal count ended the burst.

Top module: `burst_req_gen`

## Requirements
- R1: An I/O write strobe to address CTRL_ADDR while idle starts a burst: drq is high from the cycle after the write.
- R2: An I/O write to any other address leaves drq low.
- R3: A byte is counted once per rising edge of xfer_stb sampled while dack is high. A strobe held high over several cycles counts once, and a strobe pulse with dack low is not counted.
- R4: drq falls on the clock edge that counts byte number BURST_LEN (16 by default) of the burst.
- R5: tc high while drq is high ends the burst on that clock edge, even before BURST_LEN bytes, and sets ended_on_tc to 1.
- R6: While a burst is active, idle cycles with dack low and no tc do not end it.
- R7: A write to CTRL_ADDR during an active burst is ignored: the burst still ends after the number of bytes left in the original count.
- R8: burst_done is high for exactly one cycle, the first cycle with drq low after a burst. ended_on_tc keeps its value (1 = terminal count, 0 = length limit) until the next burst ends.
- R9: A synchronous active-high rst forces idle: drq, burst_done and ended_on_tc low and the byte counter cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | ADDR_W | I/O address of the write |
| dack | input | 1 | DMA acknowledge from the controller |
| tc | input | 1 | Terminal count from the controller |
| xfer_stb | input | 1 | Per-byte transfer strobe |
| drq | output | 1 | DMA request to the controller |
| burst_done | output | 1 | One-cycle pulse when a burst has ended |
| ended_on_tc | output | 1 | Sticky: last burst ended on terminal count |

## Verification
The bench builds the block with ADDR_W = 8, BURST_LEN = 16 and CTRL_ADDR = 8'h3A, so the full default burst length is run. Driving more byte attempts than the limit shows that the request drops on the sixteenth byte and not later. With 16 bytes, the bench can also place terminal count on byte 5, and on the same byte as the limit. It can issue a control write halfway through a burst, where a restart would need 24 bytes instead of 16. It also checks ignored strobes, a held strobe, and a reset in the middle of a burst.

// File: rtl/brg_pkg.sv
package brg_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } brg_state_e;

  typedef struct packed {
    logic fin;
    logic by_tc;
  } brg_end_t;

  // Decide whether the active burst finishes on this edge, and why.
  function automatic brg_end_t brg_end_eval(input logic busy, input logic tc_in,
                                            input logic beat, input logic at_last);
    brg_end_t r;
    r.by_tc = busy & tc_in;
    r.fin   = busy & (tc_in | (beat & at_last));
    return r;
  endfunction

endpackage

// File: rtl/brg_addr_match.sv
module brg_addr_match #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              hit
);

  function automatic logic f_match(input logic [ADDR_W-1:0] a);
    return a == CTRL_ADDR;
  endfunction

  assign hit = io_wr & f_match(io_addr);

endmodule

// File: rtl/brg_byte_edge.sv
module brg_byte_edge (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic dack,
  output logic byte_evt
);

  logic stb_prev;

  always_ff @(posedge clk) begin
    if (rst) stb_prev <= 1'b0;
    else     stb_prev <= stb;
  end

  assign byte_evt = stb & ~stb_prev & dack;

  // R3: a rising edge can never repeat on the very next cycle
  p_single_edge_r3: assert property (@(posedge clk) disable iff (rst)
    byte_evt |=> !byte_evt);

endmodule

// File: rtl/brg_beat_cnt.sv
module brg_beat_cnt #(
  parameter int BURST_LEN = 16,
  localparam int CNT_W = $clog2(BURST_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);

  function automatic logic [CNT_W-1:0] f_step(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic f_last(input logic [CNT_W-1:0] c);
    return c == CNT_W'(BURST_LEN - 1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (inc)     cnt <= f_step(cnt);
  end

  assign at_last = f_last(cnt);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(BURST_LEN));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0));

endmodule

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic tc,
  input  logic byte_evt,
  input  logic at_last,
  output logic start,
  output logic beat,
  output logic drq,
  output logic burst_done,
  output logic ended_on_tc
);

  brg_state_e state;
  logic       busy;
  brg_end_t   fin_info;

  assign busy     = (state == ST_BUSY);
  assign start    = ~busy & hit;
  assign beat     = busy & byte_evt;
  assign fin_info = brg_end_eval(busy, tc, beat, at_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      burst_done  <= 1'b0;
      ended_on_tc <= 1'b0;
    end else begin
      burst_done <= fin_info.fin;
      if (fin_info.fin) begin
        state       <= ST_IDLE;
        ended_on_tc <= fin_info.by_tc;
      end else if (start) begin
        state <= ST_BUSY;
      end
    end
  end

  assign drq = busy;

  p_start_raises_drq_r1: assert property (@(posedge clk) disable iff (rst)
    (!drq && hit) |=> drq);

  p_tc_drops_r5: assert property (@(posedge clk) disable iff (rst)
    (drq && tc) |=> (!drq && ended_on_tc));

  p_quiet_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (drq && !byte_evt && !tc) |=> drq);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    burst_done |=> !burst_done);

  p_done_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(drq) |-> burst_done);

  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> (!drq && !burst_done && !ended_on_tc));

endmodule

// File: rtl/burst_req_gen.sv
module burst_req_gen #(
  parameter int ADDR_W = 8,
  parameter int BURST_LEN = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h3A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              dack,
  input  logic              tc,
  input  logic              xfer_stb,
  output logic              drq,
  output logic              burst_done,
  output logic              ended_on_tc
);

  localparam int CNT_W = $clog2(BURST_LEN + 1);

  // named internal events, visible to assertions
  logic             hit;
  logic             byte_evt;
  logic             start;
  logic             beat;
  logic             at_last;
  logic [CNT_W-1:0] beat_cnt;

  brg_addr_match #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_match (
    .io_wr  (io_wr),
    .io_addr(io_addr),
    .hit    (hit)
  );

  brg_byte_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .stb     (xfer_stb),
    .dack    (dack),
    .byte_evt(byte_evt)
  );

  brg_beat_cnt #(.BURST_LEN(BURST_LEN)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clear  (start),
    .inc    (beat),
    .cnt    (beat_cnt),
    .at_last(at_last)
  );

  brg_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .hit        (hit),
    .tc         (tc),
    .byte_evt   (byte_evt),
    .at_last    (at_last),
    .start      (start),
    .beat       (beat),
    .drq        (drq),
    .burst_done (burst_done),
    .ended_on_tc(ended_on_tc)
  );

  // R7: a hit during a burst must not clear the count
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (drq && hit && !burst_done) |=> (beat_cnt >= $past(beat_cnt)));

endmodule

// File: tb/tb_burst_req_gen.sv
module tb_burst_req_gen;

  localparam int ADDR_W = 8;
  localparam int BLEN   = 16;
  localparam logic [7:0] CADDR = 8'h3A;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_wr = 1'b0;
  logic [7:0] io_addr = '0;
  logic       dack = 1'b0;
  logic       tc = 1'b0;
  logic       xfer_stb = 1'b0;
  logic       drq, burst_done, ended_on_tc;

  int errors = 0;
  int checks = 0;
  int bytes_given = 0;
  bit done_seen = 0;

  typedef struct {
    int    bytes;
    bit    by_tc;
    string req;
  } exp_t;
  exp_t expq[$];

  always #10 clk = ~clk;

  burst_req_gen #(.ADDR_W(ADDR_W), .BURST_LEN(BLEN), .CTRL_ADDR(CADDR)) dut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .dack(dack),
    .tc(tc), .xfer_stb(xfer_stb), .drq(drq), .burst_done(burst_done),
    .ended_on_tc(ended_on_tc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic io_write(input logic [7:0] a);
    io_wr = 1'b1; io_addr = a;
    @(negedge clk);
    io_wr = 1'b0; io_addr = '0;
  endtask

  // driver: push the expected outcome, then start the burst
  task automatic start_burst(input int nbytes, input bit by_tc, input string req);
    exp_t e;
    e.bytes = nbytes; e.by_tc = by_tc; e.req = req;
    bytes_given = 0;
    expq.push_back(e);
    io_write(CADDR);
    check(drq == 1'b1, "R1 drq after start", int'(drq), 1);
  endtask

  task automatic give_byte(input bit with_tc, input int hold);
    if (drq) bytes_given++;
    dack = 1'b1; xfer_stb = 1'b1; tc = with_tc;
    repeat (hold) @(negedge clk);
    xfer_stb = 1'b0; tc = 1'b0;
    @(negedge clk);
    dack = 1'b0;
    @(negedge clk);
  endtask

  // strobe pulse without acknowledge: must not count
  task automatic stray_strobe();
    xfer_stb = 1'b1;
    @(negedge clk);
    xfer_stb = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compare each completed burst against the queue
  always @(negedge clk) begin
    if (!rst) begin
      if (done_seen) begin
        check(burst_done == 1'b0, "R8 done one cycle", int'(burst_done), 0);
        done_seen = 0;
      end
      if (burst_done) begin
        done_seen = 1;
        check(drq == 1'b0, "R8 drq low with done", int'(drq), 0);
        if (expq.size() == 0) begin
          check(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(bytes_given == e.bytes, e.req, bytes_given, e.bytes);
          check(ended_on_tc == e.by_tc, {e.req, " tc flag"}, int'(ended_on_tc), int'(e.by_tc));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R9 reset state
    check(drq == 1'b0, "R9 reset drq", int'(drq), 0);
    check(burst_done == 1'b0, "R9 reset done", int'(burst_done), 0);
    check(ended_on_tc == 1'b0, "R9 reset flag", int'(ended_on_tc), 0);

    // R2 other address
    io_write(8'h3B);
    check(drq == 1'b0, "R2 other address", int'(drq), 0);
    io_write(8'h00);
    check(drq == 1'b0, "R2 other address", int'(drq), 0);

    // R4 full burst, more attempts than the limit
    start_burst(16, 1'b0, "R4 sixteen bytes");
    for (int i = 0; i < 20; i++) give_byte(1'b0, 1);
    check(drq == 1'b0, "R4 drq stays low", int'(drq), 0);

    // R3 stray strobes and held strobe
    start_burst(16, 1'b0, "R3 counted bytes");
    for (int i = 0; i < 5; i++) stray_strobe();
    check(drq == 1'b1, "R3 stray strobes ignored", int'(drq), 1);
    give_byte(1'b0, 4);
    for (int i = 0; i < 17; i++) give_byte(1'b0, 1);

    // R5 early terminal count, flag sticky
    start_burst(5, 1'b1, "R5 early tc");
    for (int i = 0; i < 4; i++) give_byte(1'b0, 1);
    give_byte(1'b1, 1);
    repeat (6) @(negedge clk);
    check(ended_on_tc == 1'b1, "R8 flag sticky", int'(ended_on_tc), 1);

    // R6 gaps and R7 write during the burst
    start_burst(16, 1'b0, "R7 write ignored");
    for (int i = 0; i < 8; i++) give_byte(1'b0, 1);
    repeat (10) @(negedge clk);
    check(drq == 1'b1, "R6 gap keeps drq", int'(drq), 1);
    io_write(CADDR);
    for (int i = 0; i < 12; i++) give_byte(1'b0, 1);

    // R5 tc together with the last byte
    start_burst(16, 1'b1, "R5 tc on last");
    for (int i = 0; i < 15; i++) give_byte(1'b0, 1);
    give_byte(1'b1, 1);
    repeat (2) @(negedge clk);

    // R9 reset mid-burst
    bytes_given = 0;
    io_write(CADDR);
    for (int i = 0; i < 3; i++) give_byte(1'b0, 1);
    do_reset();
    check(drq == 1'b0, "R9 reset mid-burst drq", int'(drq), 0);
    check(ended_on_tc == 1'b0, "R9 reset mid-burst flag", int'(ended_on_tc), 0);

    // R8 flag clears on a length-limited burst after reset
    start_burst(16, 1'b0, "R8 normal after reset");
    for (int i = 0; i < 16; i++) give_byte(1'b0, 1);
    repeat (3) @(negedge clk);

    check(expq.size() == 0, "R8 all bursts completed", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule